// File: doc/BRIEF.md
# SDRAM Write Burst Sequencer

This block sits on the device side of a single-data-rate synchronous DRAM interface. It receives decoded commands together with bank, column, auto-precharge flag, data and data-mask inputs. It turns every WRITE into a run of per-column write strobes for the array. The first data word is taken in the same cycle as the WRITE command. Each later word is taken on the following clock edges with no gaps. The column advances in the order set by the burst length that was selected when the WRITE arrived.

Fixed bursts of 1, 2, 4 or 8 beats wrap inside their aligned column block. A full-page burst wraps from the last column of the page to column 0 and keeps running until another command arrives. A new WRITE cuts off any burst in progress, and the data that comes with it belongs to the new burst. A command other than NOP or WRITE ends the burst without writing.

When a burst with auto precharge runs to its natural end, a precharge request for its bank is raised. A burst that is cut off gets no precharge request. Every strobe appears on the outputs one clock after the beat is sampled.

Top module: `sdram_wr_burst_seq`

## Requirements
- R1: When `cmd_i` is 2'b01 (WRITE), that cycle is itself a beat. One clock later `wr_en_o` is 1, and `wr_bank_o`, `wr_col_o` and `wr_data_o` carry the bank, column and data sampled with the command.
- R2: Each cycle with `cmd_i` = 2'b00 (NOP) while a burst is active is one beat. It produces a write one clock later, with the data of that cycle and no gap cycles between beats.
- R3: `bl_sel_i` is sampled with WRITE. 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives full page. The codes 4, 5 and 6 act as 1 beat.
- R4: In a fixed burst of length L, each beat's column is the previous column plus one, wrapping inside the L-aligned block that holds the start column.
- R5: After a fixed burst has delivered all its beats, NOP cycles produce no write, whatever is on `dq_i`.
- R6: A full-page burst never ends by itself. After column 2^COL_W-1 it goes on at column 0.
- R7: A WRITE during an active burst ends that burst at once and starts a new one, whatever the bank and column. A WRITE is accepted on every cycle.
- R8: `cmd_i` = 2'b10 or 2'b11 ends any active burst. That cycle writes nothing.
- R9: If the WRITE had `ap_i` = 1 and the fixed burst completes, `pre_req_o` = 1 with `pre_bank_o` = burst bank, in the same output cycle as the last beat's write. A full-page burst never raises it, and `ap_i` = 0 never does.
- R10: A burst ended early by a WRITE or another command raises no precharge request.
- R11: `wr_be_o[i]` = ~`dqm_i[i]` of the same beat. Bit i covers data bits 8i+7..8i. The mask changes neither the burst length nor the column order.
- R12: A synchronous active-high `rst` leaves `wr_en_o` and `pre_req_o` at 0 and no burst active, even if a WRITE is present during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 2 | Decoded command: 00 NOP, 01 WRITE, 10/11 other |
| bank_i | input | BANK_W | Bank address with WRITE |
| col_i | input | COL_W | Start column with WRITE |
| ap_i | input | 1 | Auto-precharge flag with WRITE |
| bl_sel_i | input | 3 | Burst length code |
| dq_i | input | DATA_W | Write data |
| dqm_i | input | DATA_W/8 | Data mask, one bit per byte lane |
| wr_en_o | output | 1 | Array write strobe |
| wr_bank_o | output | BANK_W | Bank of the write |
| wr_col_o | output | COL_W | Column of the write |
| wr_data_o | output | DATA_W | Data of the write |
| wr_be_o | output | DATA_W/8 | Byte-lane write enables |
| pre_req_o | output | 1 | Precharge request pulse |
| pre_bank_o | output | BANK_W | Bank to precharge |

## Verification
The bench starts fixed bursts close to the end of their aligned block. A column generator that carried into the upper bits would write outside the block instead of wrapping. It also runs a full-page burst across the top column to catch a design that stops or saturates there. It issues WRITEs on consecutive cycles, and on a burst's very last beat, to catch designs that still add a stale beat or still issue a precharge for a cut-off burst. Other commands that arrive in the middle of a full-page or auto-precharge burst show whether a design ignores them or leaks a precharge.

// File: rtl/sdram_wb_pkg.sv
package sdram_wb_pkg;
   typedef enum logic [1:0] {
      CMD_NOP   = 2'b00,
      CMD_WRITE = 2'b01,
      CMD_OTH_A = 2'b10,
      CMD_OTH_B = 2'b11
   } cmd_e;

   localparam int MAX_FIXED_BL = 8;
   localparam int REM_W        = $clog2(MAX_FIXED_BL);
   localparam logic [2:0] BL_FULL_PAGE = 3'd7;

   // beats minus one for the fixed burst codes; reserved codes act as single beat
   function automatic logic [REM_W-1:0] len_minus1(input logic [2:0] code);
      case (code)
         3'd1:    len_minus1 = REM_W'(1);
         3'd2:    len_minus1 = REM_W'(3);
         3'd3:    len_minus1 = REM_W'(7);
         default: len_minus1 = '0;
      endcase
   endfunction
endpackage

// File: rtl/sdram_wb_colgen.sv
module sdram_wb_colgen #(
   parameter int COL_W = 9,
   parameter int SPAN_W = 3
) (
   input  logic [COL_W-1:0]  col_i,
   input  logic [SPAN_W-1:0] span_mask_i,
   input  logic              full_i,
   output logic [COL_W-1:0]  col_next_o
);
   localparam logic [COL_W-1:0] ONE = COL_W'(1);

   logic [COL_W-1:0] mask_ext;
   logic [COL_W-1:0] inc;

   assign mask_ext = COL_W'(span_mask_i);
   assign inc      = col_i + ONE;

   // full page rolls over the whole page, fixed bursts only inside their block
   assign col_next_o = full_i ? inc : ((col_i & ~mask_ext) | (inc & mask_ext));
endmodule

// File: rtl/sdram_wb_ctrl.sv
module sdram_wb_ctrl
   import sdram_wb_pkg::*;
#(
   parameter int BANK_W = 2,
   parameter int COL_W  = 9
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        cmd_i,
   input  logic [BANK_W-1:0] bank_i,
   input  logic [COL_W-1:0]  col_i,
   input  logic              ap_i,
   input  logic [2:0]        bl_sel_i,
   output logic              beat_v_o,
   output logic [BANK_W-1:0] beat_bank_o,
   output logic [COL_W-1:0]  beat_col_o,
   output logic              beat_pre_o
);
   cmd_e cmd;
   assign cmd = cmd_e'(cmd_i);

   logic              act_q;
   logic              full_q;
   logic              ap_q;
   logic [BANK_W-1:0] bank_q;
   logic [COL_W-1:0]  col_q;
   logic [REM_W-1:0]  rem_q;
   logic [REM_W-1:0]  mask_q;

   logic              cur_full, cur_ap, last;
   logic [REM_W-1:0]  cur_rem, cur_mask;
   logic [COL_W-1:0]  col_nxt;

   always_comb begin
      if (cmd == CMD_WRITE) begin
         beat_v_o    = 1'b1;
         beat_bank_o = bank_i;
         beat_col_o  = col_i;
         cur_full    = (bl_sel_i == BL_FULL_PAGE);
         cur_mask    = len_minus1(bl_sel_i);
         cur_rem     = len_minus1(bl_sel_i);
         cur_ap      = ap_i;
      end else begin
         beat_v_o    = (cmd == CMD_NOP) && act_q;
         beat_bank_o = bank_q;
         beat_col_o  = col_q;
         cur_full    = full_q;
         cur_mask    = mask_q;
         cur_rem     = rem_q;
         cur_ap      = ap_q;
      end
      last       = !cur_full && (cur_rem == '0);
      beat_pre_o = beat_v_o && last && cur_ap;
   end

   sdram_wb_colgen #(.COL_W(COL_W), .SPAN_W(REM_W)) u_colgen (
      .col_i       (beat_col_o),
      .span_mask_i (cur_mask),
      .full_i      (cur_full),
      .col_next_o  (col_nxt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         act_q  <= 1'b0;
         full_q <= 1'b0;
         ap_q   <= 1'b0;
         bank_q <= '0;
         col_q  <= '0;
         rem_q  <= '0;
         mask_q <= '0;
      end else begin
         act_q <= beat_v_o && !last;
         if (beat_v_o) begin
            full_q <= cur_full;
            ap_q   <= cur_ap;
            bank_q <= beat_bank_o;
            col_q  <= col_nxt;
            rem_q  <= cur_rem - REM_W'(1);
            mask_q <= cur_mask;
         end
      end
   end

   // an idle sequencer only starts on a WRITE
   p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
      (!act_q && cmd != CMD_WRITE) |-> !beat_v_o);

   // a fixed burst never holds more than the longest fixed length
   p_rem_range_r3: assert property (@(posedge clk) disable iff (rst)
      (act_q && !full_q) |-> (rem_q <= REM_W'(MAX_FIXED_BL - 2)));
endmodule

// File: rtl/sdram_wb_outreg.sv
module sdram_wb_outreg #(
   parameter int BANK_W = 2,
   parameter int COL_W  = 9,
   parameter int DATA_W = 16,
   localparam int MASK_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              beat_v_i,
   input  logic [BANK_W-1:0] beat_bank_i,
   input  logic [COL_W-1:0]  beat_col_i,
   input  logic              beat_pre_i,
   input  logic [DATA_W-1:0] dq_i,
   input  logic [MASK_W-1:0] dqm_i,
   output logic              wr_en_o,
   output logic [BANK_W-1:0] wr_bank_o,
   output logic [COL_W-1:0]  wr_col_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic [MASK_W-1:0] wr_be_o,
   output logic              pre_req_o,
   output logic [BANK_W-1:0] pre_bank_o
);
   logic [MASK_W-1:0] be_n;

   for (genvar ln = 0; ln < MASK_W; ln++) begin : g_lane
      assign be_n[ln] = ~dqm_i[ln];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_en_o    <= 1'b0;
         wr_bank_o  <= '0;
         wr_col_o   <= '0;
         wr_data_o  <= '0;
         wr_be_o    <= '0;
         pre_req_o  <= 1'b0;
         pre_bank_o <= '0;
      end else begin
         wr_en_o   <= beat_v_i;
         pre_req_o <= beat_pre_i;
         if (beat_v_i) begin
            wr_bank_o <= beat_bank_i;
            wr_col_o  <= beat_col_i;
            wr_data_o <= dq_i;
            wr_be_o   <= be_n;
         end
         if (beat_pre_i) pre_bank_o <= beat_bank_i;
      end
   end
endmodule

// File: rtl/sdram_wr_burst_seq.sv
module sdram_wr_burst_seq #(
   parameter int BANK_W = 2,
   parameter int COL_W  = 9,
   parameter int DATA_W = 16,
   localparam int MASK_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        cmd_i,
   input  logic [BANK_W-1:0] bank_i,
   input  logic [COL_W-1:0]  col_i,
   input  logic              ap_i,
   input  logic [2:0]        bl_sel_i,
   input  logic [DATA_W-1:0] dq_i,
   input  logic [MASK_W-1:0] dqm_i,
   output logic              wr_en_o,
   output logic [BANK_W-1:0] wr_bank_o,
   output logic [COL_W-1:0]  wr_col_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic [MASK_W-1:0] wr_be_o,
   output logic              pre_req_o,
   output logic [BANK_W-1:0] pre_bank_o
);
   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data_w
      $error("sdram_wr_burst_seq: DATA_W must be a nonzero multiple of 8");
   end
   if (COL_W < 3) begin : g_bad_col_w
      $error("sdram_wr_burst_seq: COL_W must hold an 8-beat block");
   end
   if (BANK_W < 1) begin : g_bad_bank_w
      $error("sdram_wr_burst_seq: BANK_W must be at least 1");
   end

   logic              beat_v, beat_pre;
   logic [BANK_W-1:0] beat_bank;
   logic [COL_W-1:0]  beat_col;

   sdram_wb_ctrl #(.BANK_W(BANK_W), .COL_W(COL_W)) u_ctrl (
      .clk         (clk),
      .rst         (rst),
      .cmd_i       (cmd_i),
      .bank_i      (bank_i),
      .col_i       (col_i),
      .ap_i        (ap_i),
      .bl_sel_i    (bl_sel_i),
      .beat_v_o    (beat_v),
      .beat_bank_o (beat_bank),
      .beat_col_o  (beat_col),
      .beat_pre_o  (beat_pre)
   );

   sdram_wb_outreg #(.BANK_W(BANK_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_out (
      .clk         (clk),
      .rst         (rst),
      .beat_v_i    (beat_v),
      .beat_bank_i (beat_bank),
      .beat_col_i  (beat_col),
      .beat_pre_i  (beat_pre),
      .dq_i        (dq_i),
      .dqm_i       (dqm_i),
      .wr_en_o     (wr_en_o),
      .wr_bank_o   (wr_bank_o),
      .wr_col_o    (wr_col_o),
      .wr_data_o   (wr_data_o),
      .wr_be_o     (wr_be_o),
      .pre_req_o   (pre_req_o),
      .pre_bank_o  (pre_bank_o)
   );

   p_first_beat_r1: assert property (@(posedge clk) disable iff (rst)
      (cmd_i == 2'b01) |=> (wr_en_o && wr_col_o == $past(col_i) && wr_bank_o == $past(bank_i)));

   p_new_data_r7: assert property (@(posedge clk) disable iff (rst)
      (cmd_i == 2'b01) |=> (wr_data_o == $past(dq_i)));

   p_other_stops_r8: assert property (@(posedge clk) disable iff (rst)
      cmd_i[1] |=> !wr_en_o);

   p_pre_with_last_r9: assert property (@(posedge clk) disable iff (rst)
      pre_req_o |-> (wr_en_o && pre_bank_o == wr_bank_o));

   p_lane_mask_r11: assert property (@(posedge clk) disable iff (rst)
      (cmd_i == 2'b01) |=> (wr_be_o == ~$past(dqm_i)));
endmodule

// File: tb/sdram_wr_burst_seq_bench.sv
`timescale 1ns/1ps
module sdram_wr_burst_seq_bench;
   localparam int BW = 2, CW = 9, DW = 16, MW = DW / 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [1:0]    cmd = 2'b00;
   logic [BW-1:0] bank = '0;
   logic [CW-1:0] col = '0;
   logic          ap = 1'b0;
   logic [2:0]    bl = 3'd0;
   logic [DW-1:0] dq = '0;
   logic [MW-1:0] dqm = '0;
   logic          wr_en, pre_req;
   logic [BW-1:0] wr_bank, pre_bank;
   logic [CW-1:0] wr_col;
   logic [DW-1:0] wr_data;
   logic [MW-1:0] wr_be;

   int total = 0, bad = 0;
   logic finished = 1'b0;

   // behavioural reference state
   int  m_act = 0, m_full = 0, m_ap = 0, m_bank = 0, m_col = 0, m_rem = 0, m_len = 1;
   int  dseq = 16'h1000;

   always #2 clk = ~clk;

   sdram_wr_burst_seq #(.BANK_W(BW), .COL_W(CW), .DATA_W(DW)) u_sdram_wr_burst_seq (
      .clk(clk), .rst(rst), .cmd_i(cmd), .bank_i(bank), .col_i(col), .ap_i(ap),
      .bl_sel_i(bl), .dq_i(dq), .dqm_i(dqm), .wr_en_o(wr_en), .wr_bank_o(wr_bank),
      .wr_col_o(wr_col), .wr_data_o(wr_data), .wr_be_o(wr_be), .pre_req_o(pre_req),
      .pre_bank_o(pre_bank));

   function automatic int beats_of(input logic [2:0] s);
      case (s)
         3'd1: return 2;
         3'd2: return 4;
         3'd3: return 8;
         default: return 1;
      endcase
   endfunction

   function automatic int advance(input int c, input int len, input int full);
      int base;
      if (full != 0) return (c + 1) % (1 << CW);
      base = c - (c % len);
      return base + ((c - base + 1) % len);
   endfunction

   // one cycle: drive, predict, clock, compare
   task automatic step(input logic r, input logic [1:0] c, input int b, input int cl,
                       input logic a, input logic [2:0] s, input logic [MW-1:0] m,
                       input string tag);
      int e_en = 0, e_pre = 0, e_col = 0, e_bank = 0, last = 0;
      logic [DW-1:0] e_dat;
      rst = r; cmd = c; bank = BW'(b); col = CW'(cl); ap = a; bl = s; dqm = m;
      dseq = dseq + 16'h0137; dq = DW'(dseq);
      e_dat = dq;
      if (r) begin
         m_act = 0;
      end else if (c == 2'b01) begin
         e_en = 1; e_col = cl; e_bank = b;
         m_len = beats_of(s); m_full = (s == 3'd7) ? 1 : 0;
         m_ap = a ? 1 : 0; m_bank = b;
         last = (m_full == 0 && m_len == 1) ? 1 : 0;
         e_pre = (last != 0 && m_ap != 0) ? 1 : 0;
         m_rem = m_len - 1;
         m_col = advance(cl, m_len, m_full);
         m_act = (last == 0) ? 1 : 0;
      end else if (c == 2'b00 && m_act != 0) begin
         e_en = 1; e_col = m_col; e_bank = m_bank;
         last = (m_full == 0 && m_rem == 1) ? 1 : 0;
         e_pre = (last != 0 && m_ap != 0) ? 1 : 0;
         m_rem = m_rem - 1;
         m_col = advance(m_col, m_len, m_full);
         m_act = (last == 0) ? 1 : 0;
      end else if (c != 2'b00) begin
         m_act = 0;
      end
      @(posedge clk);
      @(negedge clk);
      total++;
      if (wr_en !== (e_en != 0) || pre_req !== (e_pre != 0) ||
          (e_en != 0 && (wr_col !== CW'(e_col) || wr_bank !== BW'(e_bank) ||
                         wr_data !== e_dat || wr_be !== ~m)) ||
          (e_pre != 0 && pre_bank !== BW'(e_bank))) begin
         bad++;
         $display("FAIL %s: got en=%0b col=%0d bank=%0d data=%h be=%b pre=%0b pbank=%0d exp en=%0d col=%0d bank=%0d data=%h be=%b pre=%0d",
                  tag, wr_en, wr_col, wr_bank, wr_data, wr_be, pre_req, pre_bank,
                  e_en, e_col, e_bank, e_dat, ~m, e_pre);
      end
   endtask

   initial begin
      @(negedge clk);
      // R12: reset holds everything quiet even with a WRITE present
      step(1, 2'b01, 1, 4, 1, 3'd0, 2'b00, "R12");
      step(1, 2'b01, 2, 8, 1, 3'd3, 2'b00, "R12");
      step(0, 2'b00, 0, 0, 0, 3'd0, 2'b00, "R12");
      // R1 R2 R4: 4-beat burst starting near block end, then R5 trailing NOPs
      step(0, 2'b01, 1, 6, 0, 3'd2, 2'b00, "R1");
      for (int i = 0; i < 3; i++) step(0, 2'b00, 0, 0, 0, 3'd0, 2'b00, "R4");
      for (int i = 0; i < 3; i++) step(0, 2'b00, 3, 99, 1, 3'd3, 2'b00, "R5");
      // R9: 8-beat with auto precharge, R4 wrap in aligned block of 8
      step(0, 2'b01, 2, 13, 1, 3'd3, 2'b01, "R9");
      for (int i = 0; i < 8; i++) step(0, 2'b00, 0, 0, 0, 3'd0, MW'(i), "R9");
      // R9: single beat with precharge; ap clear gives none
      step(0, 2'b01, 3, 40, 1, 3'd0, 2'b10, "R9");
      step(0, 2'b01, 0, 41, 0, 3'd0, 2'b00, "R9");
      step(0, 2'b00, 0, 0, 0, 3'd0, 2'b00, "R5");
      // R3: reserved codes act as one beat
      step(0, 2'b01, 1, 77, 0, 3'd5, 2'b00, "R3");
      step(0, 2'b00, 0, 0, 0, 3'd0, 2'b00, "R3");
      step(0, 2'b01, 1, 30, 0, 3'd1, 2'b00, "R3");
      step(0, 2'b00, 0, 0, 0, 3'd0, 2'b00, "R3");
      step(0, 2'b00, 0, 0, 0, 3'd0, 2'b00, "R3");
      // R7 R10: truncation of a precharging burst by WRITEs every cycle
      step(0, 2'b01, 2, 100, 1, 3'd3, 2'b00, "R10");
      step(0, 2'b00, 0, 0, 0, 3'd0, 2'b00, "R10");
      step(0, 2'b01, 0, 200, 1, 3'd2, 2'b11, "R7");
      step(0, 2'b01, 0, 57, 0, 3'd1, 2'b00, "R7");
      step(0, 2'b01, 3, 300, 1, 3'd1, 2'b01, "R7");
      step(0, 2'b00, 0, 0, 0, 3'd0, 2'b00, "R10");
      step(0, 2'b00, 0, 0, 0, 3'd0, 2'b00, "R5");
      // R10: WRITE on the last beat of a 2-beat precharging burst
      step(0, 2'b01, 1, 8, 1, 3'd1, 2'b00, "R10");
      step(0, 2'b01, 2, 9, 0, 3'd0, 2'b00, "R10");
      // R6: full page wraps past the top column, R8 other command ends it
      step(0, 2'b01, 1, 509, 1, 3'd7, 2'b00, "R6");
      for (int i = 0; i < 5; i++) step(0, 2'b00, 0, 0, 0, 3'd0, MW'(i), "R6");
      step(0, 2'b10, 0, 0, 0, 3'd0, 2'b00, "R8");
      step(0, 2'b00, 0, 0, 0, 3'd0, 2'b00, "R8");
      // R8 R10: other command cuts an 8-beat precharging burst
      step(0, 2'b01, 3, 16, 1, 3'd3, 2'b00, "R8");
      step(0, 2'b00, 0, 0, 0, 3'd0, 2'b00, "R8");
      step(0, 2'b11, 0, 0, 0, 3'd0, 2'b00, "R10");
      for (int i = 0; i < 6; i++) step(0, 2'b00, 0, 0, 0, 3'd0, 2'b00, "R10");
      // R11: masks per beat leave length and order alone
      step(0, 2'b01, 0, 3, 1, 3'd2, 2'b11, "R11");
      step(0, 2'b00, 0, 0, 0, 3'd0, 2'b10, "R11");
      step(0, 2'b00, 0, 0, 0, 3'd0, 2'b01, "R11");
      step(0, 2'b00, 0, 0, 0, 3'd0, 2'b11, "R11");
      step(0, 2'b00, 0, 0, 0, 3'd0, 2'b00, "R11");
      // R12: reset in mid burst
      step(0, 2'b01, 2, 64, 1, 3'd7, 2'b00, "R12");
      step(1, 2'b00, 0, 0, 0, 3'd0, 2'b00, "R12");
      step(0, 2'b00, 0, 0, 0, 3'd0, 2'b00, "R12");
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog R12: got hung run exp completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule